// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host CPU's byte bus and a parallel NOR flash used for saved data. It watches every host write for a three-write unlock pattern (0xAA at device offset 0x5555, then 0x55 at 0x2AAA, then a command byte at 0x5555). It uses the command to move the device between array reads, identification reads and a boot-block state. Writes that do not complete the pattern are not lost. Every write that the tracker had held back is played out again, in arrival order, as an ordinary data write on a forwarding port that feeds the array's programming path.

Reads are answered combinationally. In array mode the block drives the masked device offset to the external array and returns its byte. In identification mode it returns a 16-bit product code, one byte per offset. In boot-block mode it returns all ones. The device may occupy both byte lanes or only the even or only the odd lane. In the single-lane cases, host accesses on the other lane have no effect, and the host address is halved before decoding. Erase and sector protection commands are recognised and then ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the mode output is 0, `wr_ready` is 1, nothing is forwarded, the unlock tracker is idle and the alternate-table flag is clear.
- R2: The `mode` output encodes array mode as 0, identification mode as 1 and boot-block mode as 2. The value 3 never appears.
- R3: A write of 0xAA to offset 0x5555, followed by 0x55 to 0x2AAA, followed by any byte to 0x5555, forms a command. None of these three writes is forwarded.
- R4: When the alternate flag is clear, command 0x80 sets the flag, 0x90 enters identification mode and 0xF0 enters array mode. Every other byte, 0xA0 included, leaves the mode unchanged.
- R5: When the alternate flag is set, command 0x40 enters boot-block mode and 0x60 enters identification mode. Commands 0x10 and 0x20 leave the mode unchanged. Each of these four clears the flag. Any other byte changes neither the mode nor the flag.
- R6: In array mode, a read returns `arr_rdata`, and `arr_addr` carries the decoded offset. In boot-block mode a read returns 0xFF. In identification mode, offset 0 returns bits 15:8 of the product code, offset 1 returns bits 7:0, and any other offset returns 0xFE.
- R7: If the second write breaks the pattern, the decoder forwards (0x5555, 0xAA) and then the breaking write. If the third write is not at 0x5555, it forwards (0x5555, 0xAA), then (0x2AAA, 0x55), then the third write. In both cases the tracker returns to idle.
- R8: Each replayed or plain data write is judged against the mode at the time it plays out. In array mode it is forwarded. In identification mode it is dropped. In boot-block mode it is dropped and the mode returns to array.
- R9: Suppose a write that produces n replay slots is accepted at clock edge k. Slot i is then played out at edge k+1+i, and `wr_ready` stays low from edge k until edge k+n.
- R10: With the even-lane configuration, host writes with address bit 0 set have no effect, and reads with address bit 0 set return 0xFF. The device offset is the host address shifted right by one and truncated to `DEV_AW` bits, so host addresses that differ only above the device size decode to the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write request |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | 8 | Host write byte |
| wr_ready | output | 1 | Write accepted this cycle when high; low while replays drain |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 8 | Read byte for the current mode |
| arr_addr | output | DEV_AW | Decoded offset sent to the external array |
| arr_rdata | input | 8 | Array byte at `arr_addr` |
| mode | output | 2 | Current mode: 0 array, 1 identification, 2 boot block |
| fwd_we | output | 1 | One-cycle strobe of a data write to the array path |
| fwd_addr | output | DEV_AW | Offset of the forwarded write |
| fwd_data | output | 8 | Byte of the forwarded write |

## Verification
The decoder produces results on three timings, and the bench checks each one at its own time.

- Read data is combinational. The bench checks it 1 ns after it drives the address on a falling edge.
- A mode change caused by a command takes effect at the edge that accepts the command write.
- A forwarded write appears one edge after acceptance for its first replay slot, and one more edge for each later slot.

The bench logs every forward on falling edges, together with the number of the rising edge that produced it. It compares that number with the acceptance edge plus one plus the slot index, which its model computes. Mode and forward comparisons wait until `wr_ready` is high again plus two cycles, so that no pending replay slot is missed.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

  typedef enum logic [1:0] {
    FM_ARRAY = 2'd0,
    FM_ID    = 2'd1,
    FM_BOOT  = 2'd2
  } fmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_KEY1 = 2'd1,
    SQ_KEY2 = 2'd2
  } seq_e;

  localparam logic [15:0] KEY1_OFF = 16'h5555;
  localparam logic [15:0] KEY2_OFF = 16'h2AAA;
  localparam logic [7:0]  KEY1_VAL = 8'hAA;
  localparam logic [7:0]  KEY2_VAL = 8'h55;

  // primary table
  localparam logic [7:0] CMD_ALT   = 8'h80;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_ARRAY = 8'hF0;
  // alternate table
  localparam logic [7:0] ACMD_ERASE = 8'h10;
  localparam logic [7:0] ACMD_UNPROT = 8'h20;
  localparam logic [7:0] ACMD_BOOT  = 8'h40;
  localparam logic [7:0] ACMD_ID    = 8'h60;

  localparam int REPLAY_MAX = 3;

  localparam int LANE_BOTH = 0;
  localparam int LANE_EVEN = 1;
  localparam int LANE_ODD  = 2;

  function automatic logic lane_hit(int lane, logic a0);
    return (lane == LANE_BOTH) || (lane == LANE_EVEN && !a0) || (lane == LANE_ODD && a0);
  endfunction

  function automatic logic [7:0] id_byte(logic [15:0] pid, logic at0, logic at1);
    if (at0) return pid[15:8];
    if (at1) return pid[7:0];
    return 8'hFE;
  endfunction

endpackage

// File: rtl/flash_dec_seq.sv
module flash_dec_seq
  import flash_dec_pkg::*;
#(
  parameter int DEV_AW = 18
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  acc,
  input  logic [DEV_AW-1:0]                     off,
  input  logic [7:0]                            din,
  output logic [1:0]                            push_cnt,
  output logic [REPLAY_MAX-1:0][DEV_AW-1:0]     push_addr,
  output logic [REPLAY_MAX-1:0][7:0]            push_data,
  output logic                                  cmd_set,
  output fmode_e                                cmd_mode
);

  seq_e seq_q, seq_d;
  logic alt_q, alt_d;
  logic is_k1, is_k2;

  assign is_k1 = (off == DEV_AW'(KEY1_OFF));
  assign is_k2 = (off == DEV_AW'(KEY2_OFF));

  always_comb begin
    seq_d     = seq_q;
    alt_d     = alt_q;
    push_cnt  = 2'd0;
    push_addr = '0;
    push_data = '0;
    cmd_set   = 1'b0;
    cmd_mode  = FM_ARRAY;
    if (acc) begin
      case (seq_q)
        SQ_IDLE: begin
          if (din == KEY1_VAL && is_k1) begin
            seq_d = SQ_KEY1;
          end else begin
            push_cnt     = 2'd1;
            push_addr[0] = off;
            push_data[0] = din;
          end
        end
        SQ_KEY1: begin
          seq_d = SQ_IDLE;
          if (din == KEY2_VAL && is_k2) begin
            seq_d = SQ_KEY2;
          end else begin
            push_cnt     = 2'd2;
            push_addr[0] = DEV_AW'(KEY1_OFF);
            push_data[0] = KEY1_VAL;
            push_addr[1] = off;
            push_data[1] = din;
          end
        end
        SQ_KEY2: begin
          seq_d = SQ_IDLE;
          if (is_k1) begin
            if (alt_q) begin
              case (din)
                ACMD_ERASE, ACMD_UNPROT: alt_d = 1'b0;
                ACMD_BOOT: begin
                  cmd_set  = 1'b1;
                  cmd_mode = FM_BOOT;
                  alt_d    = 1'b0;
                end
                ACMD_ID: begin
                  cmd_set  = 1'b1;
                  cmd_mode = FM_ID;
                  alt_d    = 1'b0;
                end
                default: ;
              endcase
            end else begin
              case (din)
                CMD_ALT: alt_d = 1'b1;
                CMD_ID: begin
                  cmd_set  = 1'b1;
                  cmd_mode = FM_ID;
                end
                CMD_ARRAY: begin
                  cmd_set  = 1'b1;
                  cmd_mode = FM_ARRAY;
                end
                default: ;
              endcase
            end
          end else begin
            push_cnt     = 2'd3;
            push_addr[0] = DEV_AW'(KEY1_OFF);
            push_data[0] = KEY1_VAL;
            push_addr[1] = DEV_AW'(KEY2_OFF);
            push_data[1] = KEY2_VAL;
            push_addr[2] = off;
            push_data[2] = din;
          end
        end
        default: seq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      alt_q <= 1'b0;
    end else begin
      seq_q <= seq_d;
      alt_q <= alt_d;
    end
  end

endmodule

// File: rtl/flash_dec_replayq.sv
module flash_dec_replayq #(
  parameter int DEV_AW = 18,
  parameter int DEPTH  = 3,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CW-1:0]                 ld_cnt,
  input  logic [DEPTH-1:0][DEV_AW-1:0]  ld_addr,
  input  logic [DEPTH-1:0][7:0]         ld_data,
  output logic                          pop_v,
  output logic [DEV_AW-1:0]             pop_addr,
  output logic [7:0]                    pop_data,
  output logic                          busy
);

  logic [DEPTH-1:0][DEV_AW-1:0] slot_addr;
  logic [DEPTH-1:0][7:0]        slot_data;
  logic [CW-1:0]                cnt;

  assign pop_v    = (cnt != '0);
  assign busy     = pop_v;
  assign pop_addr = slot_addr[0];
  assign pop_data = slot_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      slot_addr <= '0;
      slot_data <= '0;
    end else if (ld_cnt != '0) begin
      cnt       <= ld_cnt;
      slot_addr <= ld_addr;
      slot_data <= ld_data;
    end else if (pop_v) begin
      cnt <= cnt - 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) begin
        slot_addr[i] <= slot_addr[i+1];
        slot_data[i] <= slot_data[i+1];
      end
      slot_addr[DEPTH-1] <= '0;
      slot_data[DEPTH-1] <= '0;
    end
  end

endmodule

// File: rtl/flash_dec_mode.sv
module flash_dec_mode
  import flash_dec_pkg::*;
#(
  parameter int DEV_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_set,
  input  fmode_e            cmd_mode,
  input  logic              pop_v,
  input  logic [DEV_AW-1:0] pop_addr,
  input  logic [7:0]        pop_data,
  output fmode_e            mode_q,
  output logic              fwd_we,
  output logic [DEV_AW-1:0] fwd_addr,
  output logic [7:0]        fwd_data
);

  logic ev_store;
  logic ev_boot_exit;

  assign ev_store     = pop_v && (mode_q == FM_ARRAY);
  assign ev_boot_exit = pop_v && (mode_q == FM_BOOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= FM_ARRAY;
      fwd_we   <= 1'b0;
      fwd_addr <= '0;
      fwd_data <= '0;
    end else begin
      fwd_we <= ev_store;
      if (ev_store) begin
        fwd_addr <= pop_addr;
        fwd_data <= pop_data;
      end
      if (cmd_set) begin
        mode_q <= cmd_mode;
      end else if (ev_boot_exit) begin
        mode_q <= FM_ARRAY;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_dec_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          DEV_AW     = 18,
  parameter int          LANE       = LANE_EVEN,
  parameter logic [15:0] PRODUCT_ID = 16'hDA45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [DEV_AW-1:0] arr_addr,
  input  logic [7:0]        arr_rdata,
  output logic [1:0]        mode,
  output logic              fwd_we,
  output logic [DEV_AW-1:0] fwd_addr,
  output logic [7:0]        fwd_data
);

  localparam int SHIFT = (LANE == LANE_BOTH) ? 0 : 1;
  localparam int QCW   = $clog2(REPLAY_MAX + 1);

  function automatic logic [DEV_AW-1:0] to_off(logic [ADDR_W-1:0] a);
    return DEV_AW'(a >> SHIFT);
  endfunction

  logic                              wr_hit, rd_hit, acc, q_busy;
  logic [DEV_AW-1:0]                 wr_off, rd_off;
  logic [1:0]                        push_cnt;
  logic [REPLAY_MAX-1:0][DEV_AW-1:0] push_addr;
  logic [REPLAY_MAX-1:0][7:0]        push_data;
  logic                              cmd_set;
  fmode_e                            cmd_mode, mode_q;
  logic                              pop_v;
  logic [DEV_AW-1:0]                 pop_addr;
  logic [7:0]                        pop_data;

  assign wr_hit   = lane_hit(LANE, wr_addr[0]);
  assign rd_hit   = lane_hit(LANE, rd_addr[0]);
  assign wr_off   = to_off(wr_addr);
  assign rd_off   = to_off(rd_addr);
  assign wr_ready = !q_busy;
  assign acc      = wr_en && wr_ready && wr_hit;

  flash_dec_seq #(.DEV_AW(DEV_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .off(wr_off), .din(wr_data),
    .push_cnt(push_cnt), .push_addr(push_addr), .push_data(push_data),
    .cmd_set(cmd_set), .cmd_mode(cmd_mode)
  );

  flash_dec_replayq #(.DEV_AW(DEV_AW), .DEPTH(REPLAY_MAX)) u_q (
    .clk(clk), .rst_n(rst_n), .ld_cnt(QCW'(push_cnt)), .ld_addr(push_addr),
    .ld_data(push_data), .pop_v(pop_v), .pop_addr(pop_addr),
    .pop_data(pop_data), .busy(q_busy)
  );

  flash_dec_mode #(.DEV_AW(DEV_AW)) u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_set(cmd_set), .cmd_mode(cmd_mode),
    .pop_v(pop_v), .pop_addr(pop_addr), .pop_data(pop_data),
    .mode_q(mode_q), .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  assign mode     = mode_q;
  assign arr_addr = rd_off;

  always_comb begin
    if (!rd_hit) begin
      rd_data = 8'hFF;
    end else begin
      case (mode_q)
        FM_ARRAY: rd_data = arr_rdata;
        FM_ID:    rd_data = id_byte(PRODUCT_ID, rd_off == '0, rd_off == DEV_AW'(1));
        default:  rd_data = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/flash_dec_chk.sv
module flash_dec_chk #(
  parameter int          DEV_AW     = 18,
  parameter logic [15:0] PRODUCT_ID = 16'hDA45
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_ready,
  input logic              wr_hit,
  input logic              rd_hit,
  input logic [DEV_AW-1:0] rd_off,
  input logic [7:0]        rd_data,
  input logic [1:0]        mode,
  input logic              fwd_we
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R2

  AST_FWD_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_we |-> mode == 2'd0); // R8

  AST_FWD_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_we |-> $past(!wr_ready)); // R9

  AST_BOOT_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> rd_data == 8'hFF); // R6

  AST_ID_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && rd_hit && rd_off == '0) |-> rd_data == PRODUCT_ID[15:8]); // R6

  AST_OFF_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ready && !wr_hit) |=> (mode == $past(mode) && wr_ready)); // R10

  AST_OFF_LANE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == 8'hFF); // R10

endmodule

bind flash_cmd_decoder flash_dec_chk #(.DEV_AW(DEV_AW), .PRODUCT_ID(PRODUCT_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ready(wr_ready), .wr_hit(wr_hit),
  .rd_hit(rd_hit), .rd_off(rd_off), .rd_data(rd_data), .mode(mode), .fwd_we(fwd_we)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  localparam int          AW  = 20;
  localparam int          DW  = 15;
  localparam logic [15:0] PID = 16'hDA45;
  localparam logic [AW-1:0] K1H = 20'h0AAAA;
  localparam logic [AW-1:0] K2H = 20'h05554;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [DW-1:0] arr_addr;
  logic [7:0] arr_rdata;
  logic [1:0] mode;
  logic fwd_we;
  logic [DW-1:0] fwd_addr;
  logic [7:0] fwd_data;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DEV_AW(DW), .LANE(1), .PRODUCT_ID(PID)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_addr(rd_addr), .rd_data(rd_data), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .mode(mode), .fwd_we(fwd_we), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data)
  );

  function automatic logic [7:0] pat(logic [DW-1:0] o);
    return o[7:0] ^ {1'b0, o[14:8]};
  endfunction

  assign arr_rdata = pat(arr_addr);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int m_mode, m_seq, m_alt;
  int exp_n, log_n;
  logic [DW-1:0] exp_a[64], log_a[64];
  logic [7:0] exp_d[64], log_d[64];
  int exp_c[64], log_c[64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fwd_we && log_n < 64) begin
      log_a[log_n] = fwd_addr;
      log_d[log_n] = fwd_data;
      log_c[log_n] = cyc;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mode = 0; m_seq = 0; m_alt = 0;
    exp_n = 0; log_n = 0;
  endtask

  task automatic mdata(input logic [DW-1:0] o, input logic [7:0] d, input int slot, input int acc);
    if (m_mode == 0) begin
      exp_a[exp_n] = o; exp_d[exp_n] = d; exp_c[exp_n] = acc + 1 + slot;
      exp_n++;
    end else if (m_mode == 2) begin
      m_mode = 0;
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d);
    int acc;
    logic [DW-1:0] o;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    acc = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[0]) return;            // R10 model: odd lane ignored
    o = a[DW:1];
    case (m_seq)
      0: if (d == 8'hAA && o == 15'h5555) m_seq = 1;
         else mdata(o, d, 0, acc);
      1: begin
        m_seq = 0;
        if (d == 8'h55 && o == 15'h2AAA) m_seq = 2;
        else begin mdata(15'h5555, 8'hAA, 0, acc); mdata(o, d, 1, acc); end
      end
      default: begin
        m_seq = 0;
        if (o == 15'h5555) begin
          if (m_alt != 0) begin
            if (d == 8'h10 || d == 8'h20) m_alt = 0;
            else if (d == 8'h40) begin m_mode = 2; m_alt = 0; end
            else if (d == 8'h60) begin m_mode = 1; m_alt = 0; end
          end else begin
            if (d == 8'h80) m_alt = 1;
            else if (d == 8'h90) m_mode = 1;
            else if (d == 8'hF0) m_mode = 0;
          end
        end else begin
          mdata(15'h5555, 8'hAA, 0, acc);
          mdata(15'h2AAA, 8'h55, 1, acc);
          mdata(o, d, 2, acc);
        end
      end
    endcase
  endtask

  task automatic unlock(input logic [7:0] c);
    do_wr(K1H, 8'hAA);
    do_wr(K2H, 8'h55);
    do_wr(K1H, c);
  endtask

  task automatic settle_check(input string req);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(log_n == exp_n, {req, " forward count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_a[i] == exp_a[i], {req, " forward addr"}, log_a[i], exp_a[i]);
      chk(log_d[i] == exp_d[i], {req, " forward data"}, log_d[i], exp_d[i]);
      chk(log_c[i] == exp_c[i], {req, " R9 forward cycle"}, log_c[i], exp_c[i]);
    end
    chk(mode == m_mode[1:0], {req, " mode"}, mode, m_mode);
    exp_n = 0; log_n = 0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] o;
    logic [7:0] e;
    @(negedge clk);
    rd_addr = a;
    #1;
    o = a[DW:1];
    if (a[0]) e = 8'hFF;
    else if (m_mode == 0) e = pat(o);
    else if (m_mode == 2) e = 8'hFF;
    else if (o == 0) e = PID[15:8];
    else if (o == 1) e = PID[7:0];
    else e = 8'hFE;
    chk(rd_data == e, {req, " read"}, rd_data, e);
    if (m_mode == 0 && !a[0]) chk(arr_addr == o, {req, " R10 arr_addr"}, arr_addr, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    chk(fwd_we == 1'b0, "R1 fwd_we", fwd_we, 0);
    // R1: tracker idle, flag clear -> 0x40 from primary table does nothing
    unlock(8'h40);
    settle_check("R1");

    // R6/R10: array-mode reads, even and odd lanes, aliases above device size
    for (int i = 0; i < 64; i++) begin
      rd_chk(AW'(i), "R6");
      rd_chk(AW'(i * 977) | 20'h10000, "R10");
    end

    // R8/R9: plain data writes in array mode
    do_wr(20'h00010, 8'h3C); settle_check("R8");
    do_wr(20'h0AAAA, 8'h11); settle_check("R8");
    do_wr(20'h12346, 8'hAA); settle_check("R10");

    // R4: sweep every primary command, then probe the alternate flag
    for (int v = 0; v < 256; v++) begin
      do_reset();
      unlock(8'(v));
      settle_check("R4");
      rd_chk(20'h00000, "R6");
      rd_chk(20'h00002, "R6");
      rd_chk(20'h00004, "R6");
      unlock(8'h40);
      settle_check("R4");
    end

    // R5: sweep every alternate command, then probe whether the flag cleared
    for (int v = 0; v < 256; v++) begin
      do_reset();
      unlock(8'h80);
      unlock(8'(v));
      settle_check("R5");
      rd_chk(20'h00000, "R5");
      rd_chk(20'h00006, "R5");
      unlock(8'h90);
      settle_check("R5");
    end

    // R3/R7: broken sequences in array mode
    do_reset();
    do_wr(K1H, 8'hAA); do_wr(K2H, 8'h56); settle_check("R7");
    do_wr(K1H, 8'hAA); do_wr(K1H, 8'hAA); settle_check("R7");
    do_wr(K1H, 8'hAA); do_wr(K2H, 8'h55);
    do_wr(20'h00100, 8'h77);
    chk(wr_ready == 1'b0, "R9 stall after 3-slot break", wr_ready, 0);
    settle_check("R7");
    unlock(8'hF0); settle_check("R3");

    // R8: data writes in identification and boot-block modes
    unlock(8'h90); settle_check("R8");
    do_wr(20'h00040, 8'h12); settle_check("R8");
    do_wr(K1H, 8'hAA); do_wr(20'h00040, 8'h13); settle_check("R8");
    unlock(8'h80); unlock(8'h40); settle_check("R8");
    rd_chk(20'h00008, "R6");
    do_wr(20'h00050, 8'h99); settle_check("R8");
    unlock(8'h80); unlock(8'h40); settle_check("R7");
    do_wr(K1H, 8'hAA); do_wr(K2H, 8'h55); do_wr(20'h00200, 8'h5A);
    settle_check("R7");

    // R10: odd-lane writes ignored, aliased unlock accepted
    do_reset();
    do_wr(K1H | 20'h1, 8'hAA); do_wr(K2H | 20'h1, 8'h55); do_wr(K1H | 20'h1, 8'h90);
    settle_check("R10");
    do_wr(20'h00031, 8'h44); settle_check("R10");
    rd_chk(20'h00001, "R10");
    do_wr(K1H | 20'h20000, 8'hAA); do_wr(K2H | 20'h40000, 8'h55);
    do_wr(K1H | 20'h80000, 8'h90);
    settle_check("R10");
    rd_chk(20'h00002, "R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule